// File: doc/BRIEF.md
# Four-Digit Key-Code Accumulator

This block collects successive key codes from a keypad front end into one wide word that a display stage can read. Each key event moves the digits already held one position to the left and writes the new code into the lowest digit. The newest key therefore always appears in the least significant digit, and the oldest key sits at the top.

An entry counter records how many keys belong to the current group. Once a group holds its full number of digits, the next key starts a new group. That key clears every upper digit and becomes the only digit held. A key event is taken from the rising edge of the keypress strobe, so a held key registers only once.

With the default parameters the block holds four 4-bit codes in a 16-bit word and reports a 2-bit entry count. Debouncing, validation of the codes and display decoding happen elsewhere.

Top module: `keyseq_accum`

## Requirements
- R1: While `rst` is high, `code_word` and `entry_count` are zero. The reset is asynchronous, so both outputs clear without waiting for a clock edge.
- R2: A press that does not follow a completed group updates the word on the clock edge that sees it. The new `code_word` is the old bits [11:0] in bits [15:4] and `key_code` in bits [3:0].
- R3: While `key_strobe` stays high, later clock edges change neither `code_word` nor `entry_count`. A falling `key_strobe` also changes neither output.
- R4: Each press increments `entry_count` by one, modulo 4. After the fourth key of a group it reads 0, and after the first key it reads 1.
- R5: A press that follows a completed group of four sets `code_word` to `key_code` in bits [3:0] with bits [15:4] zero, and sets `entry_count` to 1.
- R6: When no press occurs, a change on `key_code` has no effect on `code_word` or `entry_count`.
- R7: The edge detector leaves reset remembering a low strobe. If `key_strobe` is already high at the first clock edge after reset is released, that edge counts as a press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| key_code | input | 4 | Code of the key being entered |
| key_strobe | input | 1 | Keypress level; its rising edge is one key event |
| code_word | output | 16 | Accumulated digits, newest in bits [3:0] |
| entry_count | output | 2 | Keys in the current group, modulo 4 |

## Verification
Assertions check four rules on every cycle:
- the nibble shift on an ordinary press;
- the clear-and-load on a press after a full group;
- the modulo increment of the count;
- stability of both outputs while the strobe is held high or is low.

Some behaviours only the bench scenarios can show. One is that the reset clears the outputs between clock edges. Another is that a strobe already high when reset is released is taken as a press. The bench also walks through whole groups, including a restart with code zero and single-cycle strobe pulses back to back, against its reference model.

// File: rtl/kc_pkg.sv
package kc_pkg;

   typedef enum logic [1:0] {
      KC_IDLE    = 2'd0,
      KC_SHIFT   = 2'd1,
      KC_RESTART = 2'd2
   } kc_action_t;

endpackage

// File: rtl/kc_edge.sv
module kc_edge (
   input  logic clk,
   input  logic rst,
   input  logic strobe_i,
   output logic press_o
);

   logic strobe_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) strobe_q <= 1'b0;
      else     strobe_q <= strobe_i;
   end

   assign press_o = strobe_i & ~strobe_q;

endmodule

// File: rtl/kc_ctrl.sv
module kc_ctrl
   import kc_pkg::*;
#(
   parameter int DIGITS = 4,
   localparam int CNT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             press_i,
   output kc_action_t       action_o,
   output logic [CNT_W-1:0] count_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGITS - 1);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             full_q;
   logic             full_d;

   always_comb begin
      action_o = KC_IDLE;
      cnt_d    = cnt_q;
      full_d   = full_q;
      if (press_i) begin
         if (full_q) begin
            action_o = KC_RESTART;
            cnt_d    = ONE;
            full_d   = 1'b0;
         end else begin
            action_o = KC_SHIFT;
            cnt_d    = (cnt_q == LAST) ? '0 : cnt_q + ONE;
            full_d   = (cnt_q == LAST);
         end
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt_q  <= '0;
         full_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         full_q <= full_d;
      end
   end

   assign count_o = cnt_q;

endmodule

// File: rtl/kc_lanes.sv
module kc_lanes
   import kc_pkg::*;
#(
   parameter int DIGIT_W = 4,
   parameter int DIGITS  = 4,
   localparam int VAL_W  = DIGIT_W * DIGITS
) (
   input  logic               clk,
   input  logic               rst,
   input  kc_action_t         action_i,
   input  logic [DIGIT_W-1:0] code_i,
   output logic [VAL_W-1:0]   word_o
);

   logic [DIGIT_W-1:0] lane_q [DIGITS];

   for (genvar i = 0; i < DIGITS; i++) begin : g_lane
      logic [DIGIT_W-1:0] lane_d;

      if (i == 0) begin : g_low
         always_comb begin
            lane_d = lane_q[0];
            if (action_i != KC_IDLE) lane_d = code_i;
         end
      end else begin : g_up
         always_comb begin
            unique case (action_i)
               KC_SHIFT:   lane_d = lane_q[i-1];
               KC_RESTART: lane_d = '0;
               default:    lane_d = lane_q[i];
            endcase
         end
      end

      always_ff @(posedge clk or posedge rst) begin
         if (rst) lane_q[i] <= '0;
         else     lane_q[i] <= lane_d;
      end

      assign word_o[i*DIGIT_W +: DIGIT_W] = lane_q[i];
   end

endmodule

// File: rtl/keyseq_accum.sv
module keyseq_accum
   import kc_pkg::*;
#(
   parameter int DIGIT_W = 4,
   parameter int DIGITS  = 4,
   localparam int VAL_W  = DIGIT_W * DIGITS,
   localparam int CNT_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [DIGIT_W-1:0] key_code,
   input  logic               key_strobe,
   output logic [VAL_W-1:0]   code_word,
   output logic [CNT_W-1:0]   entry_count
);

   if (DIGIT_W < 1) begin : g_bad_w
      $error("keyseq_accum: DIGIT_W must be at least 1");
   end
   if (DIGITS < 2) begin : g_bad_n
      $error("keyseq_accum: DIGITS must be at least 2");
   end

   logic       press;
   kc_action_t action;

   kc_edge u_edge (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (key_strobe),
      .press_o  (press)
   );

   kc_ctrl #(.DIGITS(DIGITS)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .press_i  (press),
      .action_o (action),
      .count_o  (entry_count)
   );

   kc_lanes #(.DIGIT_W(DIGIT_W), .DIGITS(DIGITS)) u_lanes (
      .clk      (clk),
      .rst      (rst),
      .action_i (action),
      .code_i   (key_code),
      .word_o   (code_word)
   );

endmodule

// File: rtl/kc_accum_chk.sv
module kc_accum_chk #(
   parameter int DIGIT_W = 4,
   parameter int DIGITS  = 4,
   localparam int VAL_W  = DIGIT_W * DIGITS,
   localparam int CNT_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input logic               clk,
   input logic               rst,
   input logic [DIGIT_W-1:0] key_code,
   input logic               key_strobe,
   input logic [VAL_W-1:0]   code_word,
   input logic [CNT_W-1:0]   entry_count
);

   logic prev_q;
   logic started_q;
   logic press;
   logic full;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         prev_q    <= 1'b0;
         started_q <= 1'b0;
      end else begin
         prev_q <= key_strobe;
         if (press) started_q <= 1'b1;
      end
   end

   assign press = key_strobe && !prev_q;
   assign full  = started_q && (entry_count == '0);

   // R2: an ordinary press shifts the word up by one digit
   a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
      press && !full |=> code_word ==
         {$past(code_word[VAL_W-DIGIT_W-1:0]), $past(key_code)});

   // R5: a press after a full group keeps only the new digit
   a_r5_restart: assert property (@(posedge clk) disable iff (rst)
      press && full |=> code_word == VAL_W'($past(key_code)) &&
         entry_count == CNT_W'(1));

   // R4: the count steps by one per press
   a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
      press |=> entry_count == CNT_W'($past(entry_count) + 1'b1));

   // R3: a held strobe changes nothing
   a_r3_hold_quiet: assert property (@(posedge clk) disable iff (rst)
      key_strobe && prev_q |=> $stable(code_word) && $stable(entry_count));

   // R6: with the strobe low the code input is ignored
   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !key_strobe |=> $stable(code_word) && $stable(entry_count));

endmodule

bind keyseq_accum kc_accum_chk #(.DIGIT_W(DIGIT_W), .DIGITS(DIGITS)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .key_code    (key_code),
   .key_strobe  (key_strobe),
   .code_word   (code_word),
   .entry_count (entry_count)
);

// File: tb/keyseq_accum_bench.sv
module keyseq_accum_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  key_code = '0;
   logic        key_strobe = 1'b0;
   logic [15:0] code_word;
   logic [1:0]  entry_count;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   keyseq_accum u_keyseq_accum (
      .clk         (clk),
      .rst         (rst),
      .key_code    (key_code),
      .key_strobe  (key_strobe),
      .code_word   (code_word),
      .entry_count (entry_count)
   );

   // behavioural reference model
   int    m_val = 0;
   int    m_cnt = 0;
   bit    m_started = 0;
   bit    m_prev = 0;
   string m_tag = "R1";

   always @(posedge clk or posedge rst) begin
      if (rst) begin
         m_val = 0; m_cnt = 0; m_started = 0; m_prev = 0; m_tag = "R1";
      end else begin
         if (key_strobe && !m_prev) begin
            if (m_started && m_cnt == 0) begin
               m_val = int'(key_code);
               m_tag = "R5";
            end else begin
               m_val = ((m_val << 4) | int'(key_code)) & 16'hFFFF;
               m_tag = "R2";
            end
            m_cnt = (m_cnt + 1) % 4;
            m_started = 1;
         end else begin
            m_tag = key_strobe ? "R3" : "R6";
         end
         m_prev = key_strobe;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model (R4 covers the count)
   always @(negedge clk) begin
      if (!done) begin
         check(int'(code_word) == m_val, m_tag, int'(code_word), m_val);
         check(int'(entry_count) == m_cnt, "R4", int'(entry_count), m_cnt);
      end
   end

   task automatic press(input logic [3:0] c);
      @(negedge clk);
      key_strobe = 1'b1; key_code = c;
      @(negedge clk);
      key_strobe = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(code_word == 16'h0 && entry_count == 2'd0, "R1", int'(code_word), 0);
      rst = 1'b0;
      // R6: code changes without strobe
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); key_code = 4'(i + 9);
      end
      @(negedge clk);
      check(code_word == 16'h0, "R6", int'(code_word), 0);
      // R2/R4: a full group
      press(4'h1); press(4'h2); press(4'h3); press(4'h4);
      check(code_word == 16'h1234, "R2", int'(code_word), 'h1234);
      check(entry_count == 2'd0, "R4", int'(entry_count), 0);
      // R5: restart
      press(4'h5);
      check(code_word == 16'h0005, "R5", int'(code_word), 5);
      check(entry_count == 2'd1, "R5", int'(entry_count), 1);
      // R3: hold strobe, vary code
      @(negedge clk); key_strobe = 1'b1; key_code = 4'h9;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); key_code = 4'(i);
      end
      check(code_word == 16'h0059, "R3", int'(code_word), 'h59);
      key_strobe = 1'b0;
      @(negedge clk);
      check(code_word == 16'h0059 && entry_count == 2'd2, "R3", int'(code_word), 'h59);
      press(4'h7); press(4'h8);
      check(code_word == 16'h5978, "R2", int'(code_word), 'h5978);
      press(4'h0);
      check(code_word == 16'h0000 && entry_count == 2'd1, "R5", int'(code_word), 0);
      // back-to-back single-cycle pulses
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); key_strobe = 1'b1; key_code = 4'(i + 2);
         @(negedge clk); key_strobe = 1'b0;
      end
      @(negedge clk);
      check(code_word == 16'h0234 && entry_count == 2'd0, "R4", int'(code_word), 'h234);
      // R1: asynchronous reset between edges
      @(negedge clk); #1 rst = 1'b1; #0.5;
      check(code_word == 16'h0 && entry_count == 2'd0, "R1", int'(code_word), 0);
      // R7: strobe already high when reset releases
      key_strobe = 1'b1; key_code = 4'hA;
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      check(code_word == 16'h000A, "R7", int'(code_word), 'hA);
      key_strobe = 1'b0;
      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         key_strobe = 1'($urandom_range(0, 1));
         key_code = 4'($urandom_range(0, 15));
      end
      @(negedge clk); key_strobe = 1'b0;
      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule